// File: doc/BRIEF.md
# PRBS-31 Frame Generator for a 64-Byte Eight-Word MII Bus

This block produces a continuous test stream for a 512-bit media-independent bus. Each beat carries eight 64-bit words, so 64 bytes, and one control flag per byte. The content is a PRBS-31 sequence packed into Ethernet-style frames. Each frame opens with a start character and a preamble, carries pseudo-random payload, and closes with a terminate character and idle characters. A bit-error checker at the far end can strip the overhead and compare the payload against one unbroken PRBS-31 sequence.

The generator always produces a full 512-bit word. Overhead bytes sit at fixed bus positions and take the place of generator bytes. The generator bits displaced by the overhead are not thrown away. After each first beat and each last beat of a frame, the generator state is reloaded with the 31 sequence bits that start at the first displaced bit. Those bits therefore open the next stretch of payload.

The frame geometry is fixed by parameters. `FRAME_BEATS` sets the number of beats per frame and must be at least 2. `IDLE_WORDS` sets the number of whole idle words after the terminate word and must be between 0 and 6. The resulting payload, 56 + 64·(FRAME_BEATS−2) + 8·(7−IDLE_WORDS) bytes, must be at least the Ethernet minimum of 46 bytes. The output is a valid/ready source. Once valid, it never withdraws a beat. A beat is consumed only on a cycle where both valid and ready are high. While ready is low, the presented beat holds unchanged, and the sequence does not advance.

Top module: `prbs_cgmii_framer`

## Requirements
- R1: While `rst_n` is low, `out_valid` is low. After reset is released, the first beat presented is the first beat of a frame, and its payload begins with sequence bit 0.
- R2: The first beat of every frame has byte 0 = 0xFB with its control flag set, bytes 1 to 6 = 0x55 as data, and byte 7 = 0xD5 as data. Bus byte k is `out_data[8k+7:8k]` and its flag is `out_ctrl[k]`.
- R3: The start character 0xFB appears only at byte lane 0 of a word, and only on the beat that follows the last beat of the previous frame.
- R4: On the last beat of a frame, word 7−IDLE_WORDS has 0xFD with its flag set at lane 0. Every later byte of the beat is 0x07 with its flag set, so the idle run after the terminate word is a whole number of 8-byte words.
- R5: A control flag is high only on start, terminate and idle bytes. All preamble, delimiter and payload bytes have the flag low.
- R6: The payload bytes of consecutive frames, taken in bus order (byte 0 first), form one unbroken PRBS-31 sequence. In that sequence, s[n] = s[n−28] XOR s[n−31], and s[0..30] = SEED bits 0..30. Payload byte i bit j is s[8i+j].
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_ctrl` hold their values and no beat is lost or repeated.
- R8: Once `out_valid` rises after reset, it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| out_ready | input | 1 | Sink accepts the presented beat |
| out_valid | output | 1 | A beat is presented |
| out_data | output | 512 | Eight 64-bit words, byte k at bits 8k+7..8k |
| out_ctrl | output | 64 | Per-byte control flag, bit k for byte k |

## Verification
The stream is drawn first with ready held high for several whole frames. This tests the frame layout and the payload continuity across the first-beat and last-beat reseeds, where a wrong reseed offset shows up as a broken sequence. It is then drawn under irregular ready patterns and long stalls parked on a last beat, which separate a correct hold from a generator that advances or skips while stalled. A reset in the middle of a frame checks that the stream restarts from the seed at a frame boundary, not in the middle of the old frame.

// File: rtl/prbs_framer_pkg.sv
package prbs_framer_pkg;

  localparam int unsigned PRBS_W  = 31;
  // second feedback tap sits this far above the oldest bit (31 - 28)
  localparam int unsigned TAP_OFF = 3;

  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_PRE   = 8'h55;
  localparam logic [7:0] CH_SFD   = 8'hD5;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_IDLE  = 8'h07;

  typedef enum logic [1:0] {
    BEAT_FIRST = 2'd0,
    BEAT_MID   = 2'd1,
    BEAT_LAST  = 2'd2
  } beat_kind_e;

endpackage

// File: rtl/prbs31_gen.sv
module prbs31_gen
  import prbs_framer_pkg::*;
#(
  parameter int unsigned DW      = 512,
  parameter int unsigned C_FIRST = 448,
  parameter int unsigned C_LAST  = 320,
  parameter logic [30:0] SEED    = 31'h2A5C3E17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  beat_kind_e     kind,
  output logic [DW-1:0]  word
);

  localparam int unsigned XW = DW + PRBS_W;

  logic [PRBS_W-1:0] state;
  logic [XW-1:0]     ext;

  // bit n of the result is sequence bit p+n, where state holds p..p+30
  function automatic logic [XW-1:0] expand(input logic [PRBS_W-1:0] s);
    logic [XW-1:0] x;
    x = '0;
    x[PRBS_W-1:0] = s;
    for (int n = PRBS_W; n < XW; n++) begin
      x[n] = x[n-PRBS_W] ^ x[n-PRBS_W+TAP_OFF];
    end
    return x;
  endfunction

  assign ext  = expand(state);
  assign word = ext[DW-1:0];

  // reload from the first generator bit the beat did not place on the bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED;
    end else if (adv) begin
      unique case (kind)
        BEAT_FIRST: state <= ext[C_FIRST +: PRBS_W];
        BEAT_LAST:  state <= ext[C_LAST  +: PRBS_W];
        default:    state <= ext[DW      +: PRBS_W];
      endcase
    end
  end

  // R6: an all-zero state would lock the sequence
  p_state_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import prbs_framer_pkg::*;
#(
  parameter int unsigned FRAME_BEATS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output beat_kind_e kind
);

  localparam int unsigned CW = (FRAME_BEATS > 2) ? $clog2(FRAME_BEATS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BEATS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    if (cnt == '0)            kind = BEAT_FIRST;
    else if (cnt == LAST_IDX) kind = BEAT_LAST;
    else                      kind = BEAT_MID;
  end

  // R3: a new frame opens right after a closing beat
  p_wrap_to_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind == BEAT_LAST) |=> kind == BEAT_FIRST);

  // R3: a start beat is followed by a non-start beat
  p_first_not_repeated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind == BEAT_FIRST) |=> kind != BEAT_FIRST);

endmodule

// File: rtl/frame_lane_fill.sv
module frame_lane_fill
  import prbs_framer_pkg::*;
#(
  parameter int unsigned WORDS     = 8,
  parameter int unsigned TERM_WORD = 5
) (
  input  beat_kind_e                kind,
  input  logic [WORDS*64-1:0]       gen,
  output logic [WORDS*64-1:0]       data,
  output logic [WORDS*8-1:0]        ctrl
);

  localparam int unsigned BYTES = WORDS * 8;
  localparam int unsigned TB    = TERM_WORD * 8;

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    logic [7:0] d_first, d_last;
    logic       c_first, c_last;

    // opening beat: start, preamble, delimiter, then generator shifted by a word
    if (k == 0) begin : g_f_start
      assign d_first = CH_START;
      assign c_first = 1'b1;
    end else if (k < 7) begin : g_f_pre
      assign d_first = CH_PRE;
      assign c_first = 1'b0;
    end else if (k == 7) begin : g_f_sfd
      assign d_first = CH_SFD;
      assign c_first = 1'b0;
    end else begin : g_f_pay
      assign d_first = gen[8*(k-8) +: 8];
      assign c_first = 1'b0;
    end

    // closing beat: payload words, terminate word, whole idle words
    if (k < TB) begin : g_l_pay
      assign d_last = gen[8*k +: 8];
      assign c_last = 1'b0;
    end else if (k == TB) begin : g_l_term
      assign d_last = CH_TERM;
      assign c_last = 1'b1;
    end else begin : g_l_idle
      assign d_last = CH_IDLE;
      assign c_last = 1'b1;
    end

    always_comb begin
      unique case (kind)
        BEAT_FIRST: begin data[8*k +: 8] = d_first; ctrl[k] = c_first; end
        BEAT_LAST:  begin data[8*k +: 8] = d_last;  ctrl[k] = c_last;  end
        default:    begin data[8*k +: 8] = gen[8*k +: 8]; ctrl[k] = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/prbs_cgmii_framer.sv
module prbs_cgmii_framer
  import prbs_framer_pkg::*;
#(
  parameter int unsigned WORDS       = 8,
  parameter int unsigned FRAME_BEATS = 3,
  parameter int unsigned IDLE_WORDS  = 2,
  parameter logic [30:0] SEED        = 31'h2A5C3E17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [WORDS*64-1:0]     out_data,
  output logic [WORDS*8-1:0]      out_ctrl
);

  localparam int unsigned BYTES     = WORDS * 8;
  localparam int unsigned DW        = BYTES * 8;
  localparam int unsigned TERM_WORD = WORDS - 1 - IDLE_WORDS;
  localparam int unsigned TB        = TERM_WORD * 8;
  localparam int unsigned C_FIRST   = DW - 64;
  localparam int unsigned C_LAST    = TERM_WORD * 64;

  beat_kind_e        kind;
  logic [DW-1:0]     gen_word;
  logic [DW-1:0]     fill_data;
  logic [BYTES-1:0]  fill_ctrl;
  logic              adv;

  // a new beat is built whenever the output register is empty or being drained
  assign adv = !out_valid || out_ready;

  frame_seq #(.FRAME_BEATS(FRAME_BEATS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .kind  (kind)
  );

  prbs31_gen #(
    .DW      (DW),
    .C_FIRST (C_FIRST),
    .C_LAST  (C_LAST),
    .SEED    (SEED)
  ) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .kind  (kind),
    .word  (gen_word)
  );

  frame_lane_fill #(.WORDS(WORDS), .TERM_WORD(TERM_WORD)) u_fill (
    .kind (kind),
    .gen  (gen_word),
    .data (fill_data),
    .ctrl (fill_ctrl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctrl  <= '0;
    end else if (adv) begin
      out_valid <= 1'b1;
      out_data  <= fill_data;
      out_ctrl  <= fill_ctrl;
    end
  end

  // R7: a stalled beat stays put
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl)));

  // R8: the source never withdraws
  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  // R4: terminate is followed by idles to the end of the beat
  p_term_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ctrl[TB] && out_data[8*TB +: 8] == CH_TERM)
      |-> (&out_ctrl[BYTES-1:TB]));

  for (genvar k = 0; k < BYTES; k++) begin : g_chk
    // R5: flagged bytes carry only start, terminate or idle codes
    p_ctrl_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ctrl[k]) |->
        (out_data[8*k +: 8] == CH_START || out_data[8*k +: 8] == CH_TERM ||
         out_data[8*k +: 8] == CH_IDLE));
    if (k != 0) begin : g_nz
      // R3: start never appears away from lane 0 of word 0
      p_start_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ctrl[k]) |-> out_data[8*k +: 8] != CH_START);
    end
  end

endmodule

// File: tb/prbs_cgmii_framer_bench.sv
`timescale 1ns/1ps
module prbs_cgmii_framer_bench;

  localparam int WORDS       = 8;
  localparam int FRAME_BEATS = 3;
  localparam int IDLE_WORDS  = 2;
  localparam logic [30:0] SEED = 31'h2A5C3E17;
  localparam int BYTES = WORDS * 8;
  localparam int DW    = BYTES * 8;
  localparam int TB    = (WORDS - 1 - IDLE_WORDS) * 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic             out_ready;
  logic             out_valid;
  logic [DW-1:0]    out_data;
  logic [BYTES-1:0] out_ctrl;

  prbs_cgmii_framer #(
    .WORDS(WORDS), .FRAME_BEATS(FRAME_BEATS), .IDLE_WORDS(IDLE_WORDS), .SEED(SEED)
  ) u_prbs_cgmii_framer (
    .clk(clk), .rst_n(rst_n), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ctrl(out_ctrl)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference sequence state
  logic [30:0] hist;
  int          nbits;
  int          beat_idx;
  bit          stalled_prev;
  bit          seen_valid;
  logic [DW-1:0]    saved_d;
  logic [BYTES-1:0] saved_c;

  task automatic model_reset();
    hist = '0; nbits = 0; beat_idx = 0; stalled_prev = 0; seen_valid = 0;
  endtask

  task automatic ref_byte(output logic [7:0] b);
    for (int j = 0; j < 8; j++) begin
      logic nb;
      if (nbits < 31) nb = SEED[nbits];
      else            nb = hist[3] ^ hist[0];
      hist = {nb, hist[30:1]};
      nbits++;
      b[j] = nb;
    end
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_beat();
    logic [DW-1:0]    ed;
    logic [BYTES-1:0] ec;
    bit first, last;
    first = (beat_idx == 0);
    last  = (beat_idx == FRAME_BEATS - 1);
    for (int k = 0; k < BYTES; k++) begin
      logic [7:0] b;
      if (first && k == 0)       begin ed[8*k +: 8] = 8'hFB; ec[k] = 1'b1; end
      else if (first && k < 7)   begin ed[8*k +: 8] = 8'h55; ec[k] = 1'b0; end
      else if (first && k == 7)  begin ed[8*k +: 8] = 8'hD5; ec[k] = 1'b0; end
      else if (last && k == TB)  begin ed[8*k +: 8] = 8'hFD; ec[k] = 1'b1; end
      else if (last && k > TB)   begin ed[8*k +: 8] = 8'h07; ec[k] = 1'b1; end
      else begin ref_byte(b); ed[8*k +: 8] = b; ec[k] = 1'b0; end
    end
    chk("R5 control flags", DW'(out_ctrl), DW'(ec));
    if (first)     chk("R2 R3 R6 first beat", out_data, ed);
    else if (last) chk("R4 R6 last beat", out_data, ed);
    else           chk("R6 middle beat", out_data, ed);
    beat_idx = (beat_idx + 1) % FRAME_BEATS;
  endtask

  task automatic step(input bit rdy);
    @(negedge clk);
    out_ready = rdy;
    if (stalled_prev) begin
      chk("R7 held data", out_data, saved_d);
      chk("R7 held flags", DW'(out_ctrl), DW'(saved_c));
    end
    if (seen_valid) chk("R8 valid sticky", DW'(out_valid), DW'(1));
    if (out_valid) seen_valid = 1;
    if (out_valid && rdy) check_beat();
    stalled_prev = out_valid && !rdy;
    saved_d = out_data;
    saved_c = out_ctrl;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", DW'(out_valid), DW'(0));
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic t_free_run();
    repeat (FRAME_BEATS * 6) step(1'b1);
  endtask

  task automatic t_backpressure();
    logic [15:0] pat = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
      step(pat[0]);
    end
    for (int i = 0; i < 12; i++) step(i[0]);
  endtask

  task automatic t_stall_on_last();
    int guard = 0;
    while (!(out_valid && beat_idx == FRAME_BEATS - 1) && guard < 20) begin
      step(1'b1); guard++;
    end
    repeat (5) step(1'b0);
    repeat (FRAME_BEATS * 2) step(1'b1);
  endtask

  task automatic t_midstream_reset();
    step(1'b1);
    step(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 valid drops in reset", DW'(out_valid), DW'(0));
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (FRAME_BEATS * 3) step(1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_free_run();
    t_backpressure();
    t_stall_on_last();
    t_midstream_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule